// File: doc/BRIEF.md
# Serial Frame Receiver with Masked Interrupt

This block recovers asynchronous serial frames from a single line input. It is driven by an enable strobe that arrives sixteen times per bit period. That strobe comes from a baud generator outside the block. A frame begins with a low start bit. Its data bits follow, least significant bit first; there are seven or eight of them. An optional extra bit comes next, then a high stop bit. The block does not compute parity. The extra bit is captured exactly as it arrives and is kept next to its data byte, so it can serve as an address or mark bit.

Each received frame is stored with its extra bit and a framing-error mark. Storage is either an eight-entry first-in first-out queue or a single holding register, chosen by a control input. The oldest stored frame is always shown on the read outputs, and a one-cycle read request removes it. When nothing is stored, the read outputs are forced to zero.

A data-available flag and a combined error flag are each gated by a mask input. The head entry's extra bit is gated by a third mask. The three gated terms are ORed into an active-high interrupt.

Top module: `serial_rx_irq`

## Requirements
- R1: A low level seen on a strobe starts a frame candidate. The candidate is accepted only if the line is still low on the 8th strobe after that. Otherwise the receiver returns to idle and stores nothing.
- R2: Each later bit is sampled 16 strobes after the previous sample, so near its midpoint. Data arrives least significant bit first. With `cfg_word7`=0, eight data bits are stored, and `avail` rises once the frame is stored.
- R3: With `cfg_word7`=1, seven data bits are received, and bit 7 of `rd_data` always reads 0 for that frame.
- R4: With `cfg_xbit_en`=1, one extra bit follows the data bits and is presented on `rd_xbit` with its byte. With `cfg_xbit_en`=0, no extra bit is expected and `rd_xbit` reads 0.
- R5: With `cfg_fifo_off`=0, up to 8 frames are held and read back in arrival order.
- R6: With `cfg_fifo_off`=1, a single holding register is used, so a second frame that arrives before the first is read is not stored.
- R7: A frame arriving when storage is full is discarded and sets `err_flag`. The overrun part of `err_flag` clears on the next read that removes an entry.
- R8: A low stop bit marks that frame with a framing error. `err_flag` is 1 while that frame is at the head of storage and clears once it is read.
- R9: When storage is empty, `rd_data` and `rd_xbit` are 0. A read request while empty has no effect.
- R10: `irq` = (`mask_avail` & `avail`) | (`mask_xbit` & `rd_xbit`) | (`mask_err` & `err_flag`).
- R11: After reset, `avail`, `err_flag`, `irq`, `rd_data` and `rd_xbit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling strobe, 16 per bit period |
| rx_i | input | 1 | Serial line, idle high |
| cfg_word7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_xbit_en | input | 1 | 1 expects an extra bit after the data |
| cfg_fifo_off | input | 1 | 1 selects the single holding register, 0 the 8-entry queue |
| mask_avail | input | 1 | Interrupt mask for data available |
| mask_xbit | input | 1 | Interrupt mask for the head entry's extra bit |
| mask_err | input | 1 | Interrupt mask for overrun or framing error |
| rd_req | input | 1 | One-cycle pulse that removes the head entry |
| rd_data | output | 8 | Head entry data, 0 when empty |
| rd_xbit | output | 1 | Head entry extra bit, 0 when empty |
| avail | output | 1 | Unread data is present |
| err_flag | output | 1 | Overrun, or framing error on the head entry |
| irq | output | 1 | Masked interrupt, active high |

## Verification
The bench sends a short low glitch. A receiver that trusts the first low strobe would store a spurious byte. It fills the queue past eight entries and also sends two frames in single-register mode. A design with a wrong capacity would either overwrite the oldest entry or keep the extra frame, and a design with a wrong flag path would lose the overrun indication or leave it stuck after a read. It sends a frame with a low stop bit and then reads it, to catch an error mark that is never raised or never cleared. It also sends seven-bit frames of all ones and frames with an extra bit, which expose a stale bit 7 or an extra bit that leaks through when disabled.

// File: rtl/rxu_pkg.sv
package rxu_pkg;

    // One stored frame: data byte, extra bit, framing-error mark
    typedef struct packed {
        logic [7:0] data;
        logic       xbit;
        logic       fe;
    } rx_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_XBIT,
        ST_STOP
    } rx_state_e;

endpackage

// File: rtl/rxu_sampler.sv
module rxu_sampler
    import rxu_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_i,
    input  logic      rx_i,
    input  logic      word7_i,
    input  logic      xen_i,
    output logic      frm_valid_o,
    output rx_entry_t frm_entry_o
);

    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] MID_CNT  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(OSR - 1);

    typedef struct packed {
        logic [1:0]    sync;
        rx_state_e     st;
        logic [CW-1:0] cnt;
        logic [2:0]    idx;
        logic [7:0]    data;
        logic          xbit;
        logic          word7;
        logic          xen;
        logic          vld;
        logic          fe;
    } smp_t;

    smp_t smp_d, smp_q;
    logic rx_s;
    logic [2:0] last_idx;

    assign rx_s     = smp_q.sync[1];
    assign last_idx = smp_q.word7 ? 3'd6 : 3'd7;

    always_comb begin
        smp_d      = smp_q;
        smp_d.vld  = 1'b0;
        smp_d.sync = {smp_q.sync[0], rx_i};
        if (tick_i) begin
            case (smp_q.st)
                ST_IDLE: begin
                    if (!rx_s) begin
                        smp_d.st    = ST_START;
                        smp_d.cnt   = '0;
                        smp_d.word7 = word7_i;
                        smp_d.xen   = xen_i;
                    end
                end
                ST_START: begin
                    if (smp_q.cnt == MID_CNT) begin
                        if (!rx_s) begin
                            smp_d.st   = ST_DATA;
                            smp_d.cnt  = '0;
                            smp_d.idx  = '0;
                            smp_d.data = '0;
                            smp_d.xbit = 1'b0;
                        end else begin
                            smp_d.st = ST_IDLE;
                        end
                    end else begin
                        smp_d.cnt = smp_q.cnt + CW'(1);
                    end
                end
                ST_DATA: begin
                    if (smp_q.cnt == LAST_CNT) begin
                        smp_d.cnt             = '0;
                        smp_d.data[smp_q.idx] = rx_s;
                        if (smp_q.idx == last_idx) begin
                            smp_d.st = smp_q.xen ? ST_XBIT : ST_STOP;
                        end else begin
                            smp_d.idx = smp_q.idx + 3'd1;
                        end
                    end else begin
                        smp_d.cnt = smp_q.cnt + CW'(1);
                    end
                end
                ST_XBIT: begin
                    if (smp_q.cnt == LAST_CNT) begin
                        smp_d.cnt  = '0;
                        smp_d.xbit = rx_s;
                        smp_d.st   = ST_STOP;
                    end else begin
                        smp_d.cnt = smp_q.cnt + CW'(1);
                    end
                end
                ST_STOP: begin
                    if (smp_q.cnt == LAST_CNT) begin
                        smp_d.cnt = '0;
                        smp_d.vld = 1'b1;
                        smp_d.fe  = !rx_s;
                        smp_d.st  = ST_IDLE;
                    end else begin
                        smp_d.cnt = smp_q.cnt + CW'(1);
                    end
                end
                default: smp_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q       <= '0;
            smp_q.sync  <= 2'b11;
            smp_q.st    <= ST_IDLE;
        end else begin
            smp_q <= smp_d;
        end
    end

    assign frm_valid_o      = smp_q.vld;
    assign frm_entry_o.data = smp_q.data;
    assign frm_entry_o.xbit = smp_q.xbit;
    assign frm_entry_o.fe   = smp_q.fe;

endmodule

// File: rtl/rxu_store.sv
module rxu_store
    import rxu_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      single_i,
    input  logic      push_i,
    input  rx_entry_t push_entry_i,
    input  logic      pop_req_i,
    output logic      avail_o,
    output logic [7:0] head_data_o,
    output logic      head_xbit_o,
    output logic      head_fe_o,
    output logic      overrun_o,
    output logic      full_o
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    typedef struct packed {
        rx_entry_t [DEPTH-1:0] mem;
        logic [AW-1:0]         wp;
        logic [AW-1:0]         rp;
        logic [CW-1:0]         cnt;
        logic                  ovr;
    } sto_t;

    sto_t sto_d, sto_q;
    logic [CW-1:0] cap;
    logic full, pop, accept;
    rx_entry_t head;

    assign cap    = single_i ? CW'(1) : CW'(DEPTH);
    assign full   = (sto_q.cnt >= cap);
    assign pop    = pop_req_i && (sto_q.cnt != '0);
    assign accept = push_i && (!full || pop);

    always_comb begin
        sto_d = sto_q;
        if (accept) begin
            sto_d.mem[sto_q.wp] = push_entry_i;
            sto_d.wp = (sto_q.wp == LAST_PTR) ? '0 : sto_q.wp + AW'(1);
        end
        if (pop) begin
            sto_d.rp = (sto_q.rp == LAST_PTR) ? '0 : sto_q.rp + AW'(1);
        end
        case ({accept, pop})
            2'b10:   sto_d.cnt = sto_q.cnt + CW'(1);
            2'b01:   sto_d.cnt = sto_q.cnt - CW'(1);
            default: sto_d.cnt = sto_q.cnt;
        endcase
        if (pop) begin
            sto_d.ovr = 1'b0;
        end
        if (push_i && !accept) begin
            sto_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sto_q <= '0;
        end else begin
            sto_q <= sto_d;
        end
    end

    assign head        = sto_q.mem[sto_q.rp];
    assign avail_o     = (sto_q.cnt != '0);
    assign head_data_o = avail_o ? head.data : 8'h00;
    assign head_xbit_o = avail_o & head.xbit;
    assign head_fe_o   = avail_o & head.fe;
    assign overrun_o   = sto_q.ovr;
    assign full_o      = full;

endmodule

// File: rtl/rxu_irq.sv
module rxu_irq (
    input  logic avail_i,
    input  logic xbit_i,
    input  logic head_fe_i,
    input  logic overrun_i,
    input  logic mask_avail_i,
    input  logic mask_xbit_i,
    input  logic mask_err_i,
    output logic err_o,
    output logic irq_o
);

    logic err;

    assign err   = overrun_i | head_fe_i;
    assign err_o = err;
    assign irq_o = (mask_avail_i & avail_i)
                 | (mask_xbit_i  & xbit_i)
                 | (mask_err_i   & err);

endmodule

// File: rtl/serial_rx_irq.sv
module serial_rx_irq
    import rxu_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int OSR   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       rx_i,
    input  logic       cfg_word7,
    input  logic       cfg_xbit_en,
    input  logic       cfg_fifo_off,
    input  logic       mask_avail,
    input  logic       mask_xbit,
    input  logic       mask_err,
    input  logic       rd_req,
    output logic [7:0] rd_data,
    output logic       rd_xbit,
    output logic       avail,
    output logic       err_flag,
    output logic       irq
);

    logic      frm_valid;
    rx_entry_t frm_entry;
    logic      head_fe;
    logic      overrun;
    logic      store_full;

    rxu_sampler #(.OSR(OSR)) u_sampler (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .rx_i        (rx_i),
        .word7_i     (cfg_word7),
        .xen_i       (cfg_xbit_en),
        .frm_valid_o (frm_valid),
        .frm_entry_o (frm_entry)
    );

    rxu_store #(.DEPTH(DEPTH)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .single_i     (cfg_fifo_off),
        .push_i       (frm_valid),
        .push_entry_i (frm_entry),
        .pop_req_i    (rd_req),
        .avail_o      (avail),
        .head_data_o  (rd_data),
        .head_xbit_o  (rd_xbit),
        .head_fe_o    (head_fe),
        .overrun_o    (overrun),
        .full_o       (store_full)
    );

    rxu_irq u_irq (
        .avail_i      (avail),
        .xbit_i       (rd_xbit),
        .head_fe_i    (head_fe),
        .overrun_i    (overrun),
        .mask_avail_i (mask_avail),
        .mask_xbit_i  (mask_xbit),
        .mask_err_i   (mask_err),
        .err_o        (err_flag),
        .irq_o        (irq)
    );

endmodule

// File: rtl/serial_rx_irq_chk.sv
module serial_rx_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_req,
    input logic       mask_avail,
    input logic       mask_xbit,
    input logic       mask_err,
    input logic [7:0] rd_data,
    input logic       rd_xbit,
    input logic       avail,
    input logic       err_flag,
    input logic       irq,
    input logic       frm_valid,
    input logic       frm_fe,
    input logic       store_full
);

    // R9: empty storage reads as zero
    a_r9_zero_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !avail |-> (rd_data == 8'h00 && !rd_xbit));

    // R9: a read while empty leaves storage empty
    a_r9_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !avail && !frm_valid) |=> !avail);

    // R2: a completed frame leaves data available
    a_r2_push_avail: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> avail);

    // R7: a frame dropped on full storage raises the error flag
    a_r7_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && store_full && !rd_req) |=> err_flag);

    // R8: a bad stop bit on a frame entering empty storage flags an error
    a_r8_fe_head: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && frm_fe && !avail) |=> err_flag);

    // R10: with every mask clear the interrupt stays low
    a_r10_silent_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_avail && !mask_xbit && !mask_err) |-> !irq);

    // R10: available data with its mask set drives the interrupt
    a_r10_avail_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_avail && avail) |-> irq);

endmodule

bind serial_rx_irq serial_rx_irq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd_req),
    .mask_avail (mask_avail),
    .mask_xbit  (mask_xbit),
    .mask_err   (mask_err),
    .rd_data    (rd_data),
    .rd_xbit    (rd_xbit),
    .avail      (avail),
    .err_flag   (err_flag),
    .irq        (irq),
    .frm_valid  (frm_valid),
    .frm_fe     (frm_entry.fe),
    .store_full (store_full)
);

// File: tb/serial_rx_irq_bench.sv
`timescale 1ns/1ps
module serial_rx_irq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b1;
    logic       rx_i = 1'b1;
    logic       cfg_word7 = 1'b0;
    logic       cfg_xbit_en = 1'b0;
    logic       cfg_fifo_off = 1'b0;
    logic       mask_avail = 1'b0;
    logic       mask_xbit = 1'b0;
    logic       mask_err = 1'b0;
    logic       rd_req = 1'b0;
    logic [7:0] rd_data;
    logic       rd_xbit;
    logic       avail;
    logic       err_flag;
    logic       irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    serial_rx_irq u_serial_rx_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .rx_i         (rx_i),
        .cfg_word7    (cfg_word7),
        .cfg_xbit_en  (cfg_xbit_en),
        .cfg_fifo_off (cfg_fifo_off),
        .mask_avail   (mask_avail),
        .mask_xbit    (mask_xbit),
        .mask_err     (mask_err),
        .rd_req       (rd_req),
        .rd_data      (rd_data),
        .rd_xbit      (rd_xbit),
        .avail        (avail),
        .err_flag     (err_flag),
        .irq          (irq)
    );

    task automatic check(input string req, input string what,
                         input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        @(posedge clk); #1;
        rx_i = v;
        repeat (n - 1) @(posedge clk);
    endtask

    // One frame; a bad stop is held low for 12 strobes only
    task automatic send(input logic [7:0] d, input int nbits, input logic has_x,
                        input logic x, input logic stop_ok);
        hold(1'b0, 16);
        for (int i = 0; i < nbits; i++) hold(d[i], 16);
        if (has_x) hold(x, 16);
        if (stop_ok) hold(1'b1, 16);
        else hold(1'b0, 12);
        hold(1'b1, 12);
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_expect(input string req, input logic [7:0] d, input logic x);
        @(negedge clk);
        check(req, "avail before read", avail, 1);
        check(req, "rd_data", rd_data, d);
        check(req, "rd_xbit", rd_xbit, x);
        @(posedge clk); #1;
        rd_req = 1'b1;
        @(posedge clk); #1;
        rd_req = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R11", "avail", avail, 0);
        check("R11", "rd_data", rd_data, 0);
        check("R11", "rd_xbit", rd_xbit, 0);
        check("R11", "err_flag", err_flag, 0);
        check("R11", "irq", irq, 0);
    endtask

    task automatic t_basic();
        send(8'hA5, 8, 1'b0, 1'b0, 1'b1);
        settle();
        check("R2", "avail after frame", avail, 1);
        read_expect("R2", 8'hA5, 1'b0);
        @(negedge clk);
        check("R2", "avail after read", avail, 0);
    endtask

    task automatic t_glitch();
        hold(1'b0, 3);
        hold(1'b1, 60);
        @(negedge clk);
        check("R1", "avail after glitch", avail, 0);
        send(8'h3C, 8, 1'b0, 1'b0, 1'b1);
        settle();
        read_expect("R1", 8'h3C, 1'b0);
    endtask

    task automatic t_word7();
        cfg_word7 = 1'b1;
        send(8'hFF, 7, 1'b0, 1'b0, 1'b1);
        settle();
        read_expect("R3", 8'h7F, 1'b0);
        cfg_word7 = 1'b0;
    endtask

    task automatic t_xbit();
        cfg_xbit_en = 1'b1;
        mask_xbit   = 1'b1;
        send(8'h81, 8, 1'b1, 1'b1, 1'b1);
        settle();
        check("R10", "irq from extra bit", irq, 1);
        read_expect("R4", 8'h81, 1'b1);
        @(negedge clk);
        check("R10", "irq after read", irq, 0);
        send(8'h42, 8, 1'b1, 1'b0, 1'b1);
        settle();
        check("R10", "irq with extra bit 0", irq, 0);
        read_expect("R4", 8'h42, 1'b0);
        mask_xbit   = 1'b0;
        cfg_xbit_en = 1'b0;
        send(8'h55, 8, 1'b0, 1'b0, 1'b1);
        settle();
        read_expect("R4", 8'h55, 1'b0);
    endtask

    task automatic t_full();
        for (int i = 0; i < 9; i++) send(8'(i * 17 + 3), 8, 1'b0, 1'b0, 1'b1);
        settle();
        check("R7", "err_flag on overrun", err_flag, 1);
        for (int i = 0; i < 8; i++) begin
            read_expect("R5", 8'(i * 17 + 3), 1'b0);
            if (i == 0) begin
                @(negedge clk);
                check("R7", "err_flag after read", err_flag, 0);
            end
        end
        @(negedge clk);
        check("R5", "avail after draining", avail, 0);
    endtask

    task automatic t_single();
        cfg_fifo_off = 1'b1;
        send(8'h11, 8, 1'b0, 1'b0, 1'b1);
        send(8'h22, 8, 1'b0, 1'b0, 1'b1);
        settle();
        check("R6", "err_flag on second frame", err_flag, 1);
        read_expect("R6", 8'h11, 1'b0);
        @(negedge clk);
        check("R6", "avail after one read", avail, 0);
        check("R7", "err_flag cleared", err_flag, 0);
        cfg_fifo_off = 1'b0;
    endtask

    task automatic t_frame_err();
        mask_err = 1'b1;
        send(8'h96, 8, 1'b0, 1'b0, 1'b0);
        send(8'h69, 8, 1'b0, 1'b0, 1'b1);
        settle();
        check("R8", "err_flag with bad stop at head", err_flag, 1);
        check("R10", "irq from error mask", irq, 1);
        read_expect("R8", 8'h96, 1'b0);
        @(negedge clk);
        check("R8", "err_flag after read", err_flag, 0);
        check("R10", "irq after error read", irq, 0);
        read_expect("R8", 8'h69, 1'b0);
        mask_err = 1'b0;
    endtask

    task automatic t_empty_read();
        @(posedge clk); #1;
        rd_req = 1'b1;
        @(posedge clk); #1;
        rd_req = 1'b0;
        @(negedge clk);
        check("R9", "avail after empty read", avail, 0);
        check("R9", "rd_data empty", rd_data, 0);
        check("R9", "rd_xbit empty", rd_xbit, 0);
        send(8'hC3, 8, 1'b0, 1'b0, 1'b1);
        settle();
        read_expect("R9", 8'hC3, 1'b0);
    endtask

    task automatic t_masks();
        send(8'h5A, 8, 1'b0, 1'b0, 1'b1);
        settle();
        check("R10", "irq masked off", irq, 0);
        mask_avail = 1'b1;
        @(negedge clk);
        check("R10", "irq with avail mask", irq, 1);
        read_expect("R10", 8'h5A, 1'b0);
        @(negedge clk);
        check("R10", "irq once empty", irq, 0);
        mask_avail = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired before all scenarios completed (R1..)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        #1 rst_n = 1'b1;
        repeat (4) @(posedge clk);
        t_basic();
        t_glitch();
        t_word7();
        t_xbit();
        t_full();
        t_single();
        t_frame_err();
        t_empty_read();
        t_masks();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule